// File: doc/BRIEF.md
# Interleaved SAR Section Sequencer

This block times a converter channel built from several successive-approximation sections that work in parallel. A single phase counter runs a repeating frame of clock cycles. Each section walks through the same fixed schedule across that frame: reference-zero sampling, auto-zero compare, auto-calibrate compare, input sampling, one cycle per result bit of successive approximation, and a final transfer slot. The schedules of neighbouring sections are offset by two clocks. As a result, exactly one section samples the input on every second clock, so the sample rate is half the clock rate.

The results arrive from the sections on a flat input bus. In each transfer slot, a one-of-N selector picks the section that is finishing and registers its word onto the output. A half-rate strobe marks the output words, and its rising edge falls in the middle of each word's two-cycle window. A synchronous reset puts the frame at a known phase. While reset is high, the strobe and the output-valid flag are forced low at once. A latency timer holds output-valid low until the first real result arrives. A second, longer timer raises a calibrated flag once the power-up calibration period has elapsed.

Counting the first clock cycle after reset falls as cycle 0, section 0 samples in cycle 0 and the other sections follow in ascending order.

Top module: `sar_interleave_seq`

## Requirements
- R1: While rst is high, the frame phase is held at 0, every section operation field reads 0 (hold), dout_o reads 0, and dav_o, dout_vld_o and cal_done_o read 0. dav_o and dout_vld_o drop in the same cycle that rst rises, without waiting for a clock edge.
- R2: After release, the frame phase advances once per clock, modulo 16. In cycle n, section k is at slot (n + 3 - 2k) mod 16.
- R3: Each section's 3-bit operation field sits at sect_op_o[3k+2:3k]. Slot 0 gives 1 (reference-zero), slot 1 gives 2 (auto-zero), slot 2 gives 3 (auto-calibrate), slot 3 gives 4 (sample), slots 4 to 14 give 5 (convert) and slot 15 gives 6 (transfer).
- R4: Each section's 4-bit trial-bit field sits at sect_bit_o[4k+3:4k]. In a convert slot s it reads 14 - s, which steps from bit 10 down to bit 0. In every other slot it reads 0.
- R5: Exactly one section reports sample (4) in every even cycle and none does in odd cycles. In cycle n the sampling section is (n/2) mod 8, so section 0 samples first, in cycle 0.
- R6: In every even cycle n, mux_sel_o names the section in its transfer slot, which is ((n + 4) mod 16) / 2.
- R7: The word on sect_res_i of the transferring section is registered at the end of its transfer cycle. A sample taken in cycle c therefore appears on dout_o in cycles c+13 and c+14, that is 12 clock edges after the sampling edge. dout_o does not change at other times.
- R8: dav_o is low in cycles 0 and 1. From cycle 2 on it is high in even cycles and low in odd cycles, so its rising edge comes on the second clock edge after release.
- R9: dout_vld_o is low in cycles 0 to 12 and high from cycle 13 on while rst stays low.
- R10: cal_done_o is low until CAL_CYCLES cycles have passed since release, and high from cycle CAL_CYCLES on.
- R11: A reset asserted at any phase restarts the schedule. After release the block again behaves as cycle 0, with section 0 sampling first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Converter clock, twice the sample rate |
| rst | input | 1 | Synchronous active-high reset; also gates dav_o and dout_vld_o directly |
| sect_res_i | input | SECT_N*RES_W | Finished result of each section, section k at [RES_W*k +: RES_W] |
| sect_op_o | output | SECT_N*3 | Per-section operation code for the current cycle |
| sect_bit_o | output | SECT_N*4 | Per-section bit under trial during conversion |
| mux_sel_o | output | 3 | Index of the section in its transfer slot |
| dout_o | output | RES_W | Registered result word |
| dav_o | output | 1 | Half-rate data strobe; latch dout_o on its rising edge |
| dout_vld_o | output | 1 | High once the pipeline latency after reset has elapsed |
| cal_done_o | output | 1 | High once the calibration period after reset has elapsed |

## Verification
The hardest condition to reach from the ports is a reset that lands in the middle of a frame, while the strobe is high and results are still in flight. The block must drop its strobe within that same cycle and then resume with section 0 as the first sampler. The bench reaches this by running 200 cycles of tagged traffic and raising reset just after a clock edge in a cycle where dav_o is high. It then releases reset and replays the traffic. A driver gives every sample a distinct tag on the sampling section's result input and queues the cycle in which that tag must appear. A monitor pops the queue on every output word, so any fault in order, latency or selector shows up as a wrong tag or a wrong cycle. The second run continues past the calibration period so that the edge of cal_done_o is observed exactly.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;

    typedef enum logic [2:0] {
        OP_HOLD   = 3'd0,
        OP_ZREF   = 3'd1,
        OP_AZERO  = 3'd2,
        OP_ACAL   = 3'd3,
        OP_SAMPLE = 3'd4,
        OP_CONV   = 3'd5,
        OP_XFER   = 3'd6
    } sect_op_e;

    localparam int SLOT_ZREF   = 0;
    localparam int SLOT_AZERO  = 1;
    localparam int SLOT_ACAL   = 2;
    localparam int SLOT_SAMPLE = 3;
    localparam int PRE_SLOTS   = 4;
    localparam int OP_W        = 3;

    function automatic sect_op_e op_of_slot(input int slot, input int frame);
        sect_op_e op;
        if (slot == SLOT_ZREF)        op = OP_ZREF;
        else if (slot == SLOT_AZERO)  op = OP_AZERO;
        else if (slot == SLOT_ACAL)   op = OP_ACAL;
        else if (slot == SLOT_SAMPLE) op = OP_SAMPLE;
        else if (slot == frame - 1)   op = OP_XFER;
        else                          op = OP_CONV;
        return op;
    endfunction

    function automatic int trial_bit(input int slot, input int frame);
        if (slot >= PRE_SLOTS && slot < frame - 1)
            return frame - 2 - slot;
        return 0;
    endfunction

endpackage

// File: rtl/sar_phase_gen.sv
module sar_phase_gen #(
    parameter int FRAME = 16,
    parameter int PH_W  = 4
) (
    input  logic            clk,
    input  logic            rst,
    output logic [PH_W-1:0] ph_o,
    output logic            dav_o
);
    logic [PH_W-1:0] ph_q;
    logic            dav_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q  <= '0;
            dav_q <= 1'b0;
        end else begin
            ph_q  <= (int'(ph_q) == FRAME - 1) ? '0 : ph_q + 1'b1;
            dav_q <= ph_q[0];
        end
    end

    assign ph_o  = ph_q;
    assign dav_o = dav_q & ~rst;

    // R2
    phase_step_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> int'(ph_q) == (int'($past(ph_q)) + 1) % FRAME);

    // R8
    dav_half_rate_chk: assert property (@(posedge clk) disable iff (rst)
        dav_q |=> !dav_q);

endmodule

// File: rtl/sar_sect_sched.sv
module sar_sect_sched
    import sar_seq_pkg::*;
#(
    parameter int FRAME    = 16,
    parameter int PH_W     = 4,
    parameter int STRIDE   = 2,
    parameter int SECT_IDX = 0,
    parameter int BIT_W    = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [PH_W-1:0]  ph_i,
    output sect_op_e         op_o,
    output logic [BIT_W-1:0] bit_o,
    output logic             xfer_o,
    output logic             samp_o
);
    localparam int OFFS = ((SLOT_SAMPLE - STRIDE * SECT_IDX) % FRAME + FRAME) % FRAME;

    int slot;

    always_comb begin
        slot = (int'(ph_i) + OFFS) % FRAME;
        if (rst) begin
            op_o  = OP_HOLD;
            bit_o = '0;
        end else begin
            op_o  = op_of_slot(slot, FRAME);
            bit_o = BIT_W'(trial_bit(slot, FRAME));
        end
    end

    assign xfer_o = (op_o == OP_XFER);
    assign samp_o = (op_o == OP_SAMPLE);

    // R3
    samp_then_conv_chk: assert property (@(posedge clk) disable iff (rst)
        op_o == OP_SAMPLE |=> op_o == OP_CONV);

    // R3
    xfer_then_zref_chk: assert property (@(posedge clk) disable iff (rst)
        op_o == OP_XFER |=> op_o == OP_ZREF);

endmodule

// File: rtl/sar_out_mux.sv
module sar_out_mux #(
    parameter int SECT_N = 8,
    parameter int RES_W  = 11,
    parameter int SEL_W  = 3
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [SECT_N-1:0]       xfer_i,
    input  logic [SECT_N*RES_W-1:0] res_i,
    output logic [SEL_W-1:0]        sel_o,
    output logic [RES_W-1:0]        dout_o
);
    logic [RES_W-1:0] dout_q;
    logic             any_xfer;

    always_comb begin
        sel_o = '0;
        for (int k = 0; k < SECT_N; k++)
            if (xfer_i[k]) sel_o = SEL_W'(k);
    end

    assign any_xfer = |xfer_i;

    always_ff @(posedge clk) begin
        if (rst)           dout_q <= '0;
        else if (any_xfer) dout_q <= res_i[int'(sel_o)*RES_W +: RES_W];
    end

    assign dout_o = dout_q;

    // R6
    one_xfer_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(xfer_i));

    // R7
    dout_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(any_xfer)) |-> $stable(dout_q));

endmodule

// File: rtl/sar_sat_timer.sv
module sar_sat_timer #(
    parameter int LIMIT = 13,
    parameter int CW    = $clog2(LIMIT + 1)
) (
    input  logic clk,
    input  logic rst,
    output logic done_o
);
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)                     cnt_q <= '0;
        else if (int'(cnt_q) < LIMIT) cnt_q <= cnt_q + 1'b1;
    end

    assign done_o = (int'(cnt_q) >= LIMIT);

    // R9
    done_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |=> done_o);

endmodule

// File: rtl/sar_interleave_seq.sv
module sar_interleave_seq
    import sar_seq_pkg::*;
#(
    parameter int RES_W      = 11,
    parameter int SECT_N     = 8,
    parameter int CAL_CYCLES = 10000
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [SECT_N*RES_W-1:0]     sect_res_i,
    output logic [SECT_N*OP_W-1:0]      sect_op_o,
    output logic [SECT_N*4-1:0]         sect_bit_o,
    output logic [$clog2(SECT_N)-1:0]   mux_sel_o,
    output logic [RES_W-1:0]            dout_o,
    output logic                        dav_o,
    output logic                        dout_vld_o,
    output logic                        cal_done_o
);
    localparam int FRAME   = RES_W + PRE_SLOTS + 1;
    localparam int STRIDE  = FRAME / SECT_N;
    localparam int PH_W    = $clog2(FRAME);
    localparam int SEL_W   = $clog2(SECT_N);
    localparam int BIT_W   = 4;
    localparam int LATENCY = FRAME - 1 - SLOT_SAMPLE;

    logic [PH_W-1:0]   ph;
    logic [SECT_N-1:0] xfer_vec;
    logic [SECT_N-1:0] samp_vec;
    logic              lat_done;
    logic              cal_done;

    sar_phase_gen #(.FRAME(FRAME), .PH_W(PH_W)) u_phase (
        .clk   (clk),
        .rst   (rst),
        .ph_o  (ph),
        .dav_o (dav_o)
    );

    for (genvar k = 0; k < SECT_N; k++) begin : g_sect
        sect_op_e op_k;
        sar_sect_sched #(
            .FRAME(FRAME), .PH_W(PH_W), .STRIDE(STRIDE),
            .SECT_IDX(k), .BIT_W(BIT_W)
        ) u_sched (
            .clk    (clk),
            .rst    (rst),
            .ph_i   (ph),
            .op_o   (op_k),
            .bit_o  (sect_bit_o[k*BIT_W +: BIT_W]),
            .xfer_o (xfer_vec[k]),
            .samp_o (samp_vec[k])
        );
        assign sect_op_o[k*OP_W +: OP_W] = op_k;
    end

    sar_out_mux #(.SECT_N(SECT_N), .RES_W(RES_W), .SEL_W(SEL_W)) u_mux (
        .clk    (clk),
        .rst    (rst),
        .xfer_i (xfer_vec),
        .res_i  (sect_res_i),
        .sel_o  (mux_sel_o),
        .dout_o (dout_o)
    );

    sar_sat_timer #(.LIMIT(LATENCY + 1)) u_lat (
        .clk    (clk),
        .rst    (rst),
        .done_o (lat_done)
    );

    sar_sat_timer #(.LIMIT(CAL_CYCLES)) u_cal (
        .clk    (clk),
        .rst    (rst),
        .done_o (cal_done)
    );

    assign dout_vld_o = lat_done & ~rst;
    assign cal_done_o = cal_done & ~rst;

    // R5
    one_sampler_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(samp_vec));

    // R5
    sample_spacing_chk: assert property (@(posedge clk) disable iff (rst)
        (samp_vec != '0) |=> (samp_vec == '0));

    // R1
    rst_quiet_chk: assert property (@(posedge clk)
        rst |-> (!dav_o && !dout_vld_o && sect_op_o == '0));

endmodule

// File: tb/tb_sar_interleave_seq.sv
module tb_sar_interleave_seq;
    localparam int RES_W  = 11;
    localparam int SECT_N = 8;
    localparam int CAL    = 10000;
    localparam int FRAME  = 16;

    logic                    clk = 1'b0;
    logic                    rst = 1'b1;
    logic [SECT_N*RES_W-1:0] sect_res = '0;
    logic [SECT_N*3-1:0]     sect_op;
    logic [SECT_N*4-1:0]     sect_bit;
    logic [2:0]              mux_sel;
    logic [RES_W-1:0]        dout;
    logic                    dav, dout_vld, cal_done;

    typedef struct {
        logic [RES_W-1:0] val;
        int               due;
    } exp_t;

    exp_t             sb_q[$];
    int               n_chk = 0;
    int               n_fail = 0;
    logic [RES_W-1:0] last_word = '0;
    bit               finished = 0;

    always #2 clk = ~clk;

    sar_interleave_seq #(.RES_W(RES_W), .SECT_N(SECT_N), .CAL_CYCLES(CAL)) dut (
        .clk        (clk),
        .rst        (rst),
        .sect_res_i (sect_res),
        .sect_op_o  (sect_op),
        .sect_bit_o (sect_bit),
        .mux_sel_o  (mux_sel),
        .dout_o     (dout),
        .dav_o      (dav),
        .dout_vld_o (dout_vld),
        .cal_done_o (cal_done)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
        end
    endtask

    function automatic int exp_op(input int slot);
        if (slot == 0)  return 1;
        if (slot == 1)  return 2;
        if (slot == 2)  return 3;
        if (slot == 3)  return 4;
        if (slot == 15) return 6;
        return 5;
    endfunction

    // driver: tag the sampling section and queue the expected word
    task automatic drive(input int n);
        if (n % 2 == 0) begin
            int s = (n / 2) % SECT_N;
            logic [RES_W-1:0] tag = RES_W'(n * 13 + s * 101 + 5);
            exp_t e;
            sect_res[s*RES_W +: RES_W] = tag;
            e.val = tag;
            e.due = n + 13;
            sb_q.push_back(e);
        end
    endtask

    // monitor: compare outputs in cycle n
    task automatic monitor(input int n);
        if (n < 40) begin
            int nsamp = 0;
            for (int k = 0; k < SECT_N; k++) begin
                int sl = (n + 3 - 2 * k + 2 * FRAME) % FRAME;
                int eo = exp_op(sl);
                int eb = (eo == 5) ? 14 - sl : 0;
                chk(int'(sect_op[k*3 +: 3]) == eo, "R2/R3 op field", int'(sect_op[k*3 +: 3]), eo);
                chk(int'(sect_bit[k*4 +: 4]) == eb, "R4 trial bit", int'(sect_bit[k*4 +: 4]), eb);
                if (sect_op[k*3 +: 3] == 3'd4) begin
                    nsamp++;
                    chk(k == (n / 2) % SECT_N, "R5 sampler index", k, (n / 2) % SECT_N);
                end
            end
            chk(nsamp == ((n % 2 == 0) ? 1 : 0), "R5 sampler count", nsamp, (n % 2 == 0) ? 1 : 0);
        end
        if (n % 2 == 0)
            chk(int'(mux_sel) == ((n + 4) % FRAME) / 2, "R6 mux select", int'(mux_sel), ((n + 4) % FRAME) / 2);
        chk(dav == (n >= 2 && n % 2 == 0), "R8 strobe", int'(dav), int'(n >= 2 && n % 2 == 0));
        chk(dout_vld == (n >= 13), "R9 output valid", int'(dout_vld), int'(n >= 13));
        if (n >= 13) begin
            if (n % 2 == 1) begin
                if (sb_q.size() == 0) begin
                    chk(0, "R7 scoreboard empty", int'(dout), -1);
                end else begin
                    exp_t e = sb_q.pop_front();
                    chk(dout == e.val && e.due == n, "R7 word and latency", int'(dout), int'(e.val));
                    last_word = e.val;
                end
            end else begin
                chk(dout == last_word, "R7 word held", int'(dout), int'(last_word));
            end
        end
        if (n == 0 || n == 100 || n == CAL - 1 || n == CAL || n == CAL + 5)
            chk(cal_done == (n >= CAL), "R10 calibrated flag", int'(cal_done), int'(n >= CAL));
    endtask

    task automatic run_seq(input int ncyc);
        for (int n = 0; n < ncyc; n++) begin
            drive(n);
            @(negedge clk);
            monitor(n);
            @(posedge clk);
            #1;
        end
    endtask

    task automatic check_reset_state(input string tag);
        chk(sect_op == '0, {tag, " R1 ops hold"}, int'(sect_op), 0);
        chk(dout == '0, {tag, " R1 dout cleared"}, int'(dout), 0);
        chk(!dav && !dout_vld && !cal_done, {tag, " R1 flags low"},
            int'({dav, dout_vld, cal_done}), 0);
    endtask

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        check_reset_state("initial");
        @(posedge clk);
        #1 rst = 1'b0;
        run_seq(200);
        // now at cycle 200 (even, strobe high, phase 8): reset mid-frame
        rst = 1'b1;
        #1;
        chk(!dav, "R1 strobe drops at once", int'(dav), 0);
        chk(!dout_vld, "R1 valid drops at once", int'(dout_vld), 0);
        repeat (3) @(posedge clk);
        @(negedge clk);
        check_reset_state("mid-run");
        sb_q.delete();
        last_word = '0;
        @(posedge clk);
        #1 rst = 1'b0;
        // R11: schedule restarts from cycle 0 after re-release
        run_seq(CAL + 20);
        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #(4 * 150000);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog R11 actual=timeout expected=completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule